// File: doc/BRIEF.md
# Dual-Mode Watchdog Interval Timer

This block is a 7-bit event counter that advances once for every overflow pulse from an external interval prescaler. It compares the count with a programmable 7-bit limit. When a tick would complete the limit, the block reports a match and the count restarts from zero. A single enable bit in the control register chooses what a match does. In watchdog mode it requests a system reset. In timer mode it raises a sticky interrupt flag. The time between matches is therefore the limit multiplied by the prescaler overflow period.

Software keeps the watchdog from firing by rewriting the limit register with its top bit set. That write clears the counter, and the top bit is not stored. A stop-mode input freezes the counter without losing its value. If a watchdog reset fires while the system is running from the sub clock, the block also asks for the main oscillator to be turned back on, for as long as the reset request lasts.

Top module: `dual_wdt`

## Requirements
- R1: After reset, the outputs are as follows: `cnt_o` = 0, `cmp_rd_o` = 0x7F, `irq_o` = 0, `rst_req_o` = 0, `osc_on_o` = 0, and the block is in timer mode (enable = 0).
- R2: A write to the control register sets the mode from data bit 5: 1 selects watchdog mode and 0 selects timer mode. The other data bits have no effect.
- R3: Each `tick_i` that is not stopped, not cleared and not a match increments `cnt_o` by exactly one in the next cycle.
- R4: When the limit N is from 1 to 127, the N-th accepted tick after the counter was cleared is a match, and `cnt_o` returns to 0.
- R5: When the limit is 0, every accepted tick taken while the count is 0 is a match.
- R6: In watchdog mode, a match drives `rst_req_o` high for exactly 4 clock cycles, starting in the cycle after the tick, and leaves `irq_o` unchanged. A further match while the pulse is active restarts the 4-cycle pulse.
- R7: In timer mode, a match sets `irq_o` in the next cycle and leaves `rst_req_o` low. `irq_o` stays high until `irq_clr_i` is pulsed.
- R8: A write to the limit register always loads data bits 6:0 as the new limit. If data bit 7 is 1, `cnt_o` becomes 0 in the next cycle. If data bit 7 is 0, the count is not cleared. Bit 7 of `cmp_rd_o` always reads 0.
- R9: When a tick arrives in the same cycle as a clearing write, the clear wins: the count becomes 0 and no match is reported.
- R10: While `stop_i` is high, ticks are ignored and `cnt_o` holds its value. Counting resumes from that value once `stop_i` falls.
- R11: `osc_on_o` is high exactly while `rst_req_o` is high, and only for a pulse whose match occurred with `subclk_i` = 1. Otherwise it stays 0.
- R12: When a timer-mode match and `irq_clr_i` occur in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_we_i | input | 1 | Write strobe for the control register |
| ctl_wdata_i | input | 8 | Control write data; bit 5 is the watchdog enable |
| cmp_we_i | input | 1 | Write strobe for the limit register |
| cmp_wdata_i | input | 8 | Limit write data; bits 6:0 are the limit, bit 7 clears the counter |
| tick_i | input | 1 | One-cycle overflow pulse from the prescaler |
| stop_i | input | 1 | Stop mode; freezes the counter |
| subclk_i | input | 1 | High while the system runs from the sub clock |
| irq_clr_i | input | 1 | Clears the interrupt flag |
| cnt_o | output | 7 | Current count |
| cmp_rd_o | output | 8 | Limit register read value; bit 7 always reads 0 |
| irq_o | output | 1 | Sticky interrupt flag set by timer-mode matches |
| rst_req_o | output | 1 | Reset request pulse from watchdog-mode matches |
| osc_on_o | output | 1 | Request to turn the main oscillator back on |

## Verification
The hardest situations to reach are those where several events land in the same cycle. Examples are a tick together with a clearing write, a match together with a flag clear, and a match that retriggers a reset pulse that is already running. Random stimulus sets the limit between 0 and 7, so that matches are frequent, and mixes in clearing writes, stop, mode changes and flag clears at independent rates. A cycle-by-cycle reference model computes every output. Directed sequences force each collision on purpose and also cover the full 127-tick limit.

// File: rtl/dual_wdt_pkg.sv
package dual_wdt_pkg;
  typedef enum logic {
    MODE_TIMER = 1'b0,
    MODE_WDOG  = 1'b1
  } wdt_mode_e;
endpackage

// File: rtl/dual_wdt_regs.sv
module dual_wdt_regs
  import dual_wdt_pkg::*;
#(
  parameter int unsigned CNT_W  = 7,
  parameter int unsigned CTL_W  = 8,
  parameter int unsigned EN_BIT = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W:0]   cmp_wdata_i,
  output wdt_mode_e        mode_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             clr_o
);
  wdt_mode_e        mode_q;
  logic [CNT_W-1:0] cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_TIMER;
      cmp_q  <= '1;
    end else begin
      if (ctl_we_i) mode_q <= wdt_mode_e'(ctl_wdata_i[EN_BIT]);
      if (cmp_we_i) cmp_q  <= cmp_wdata_i[CNT_W-1:0];
    end
  end

  // top data bit is a strobe, never stored
  assign clr_o  = cmp_we_i & cmp_wdata_i[CNT_W];
  assign mode_o = mode_q;
  assign cmp_o  = cmp_q;
endmodule

// File: rtl/dual_wdt_cnt.sv
module dual_wdt_cnt #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             stop_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             adv;
  logic             hit;

  always_comb begin
    adv = tick_i & ~stop_i & ~clr_i;
    // limit 0 behaves as a period of one tick
    hit = (cmp_i == '0) ? (cnt_q == '0) : ((cnt_q + ONE) == cmp_i);
    match_o = adv & hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i || match_o)  cnt_q <= '0;
    else if (adv)               cnt_q <= cnt_q + ONE;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dual_wdt_evt.sv
module dual_wdt_evt
  import dual_wdt_pkg::*;
#(
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      match_i,
  input  wdt_mode_e mode_i,
  input  logic      subclk_i,
  input  logic      irq_clr_i,
  output logic      irq_o,
  output logic      rst_req_o,
  output logic      osc_on_o
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);
  localparam logic [PW-1:0] LEN = PW'(PULSE_LEN);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic          irq_q;
  logic [PW-1:0] pulse_q;
  logic          osc_q;
  logic          wdog_hit;

  assign wdog_hit = match_i & (mode_i == MODE_WDOG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      pulse_q <= '0;
      osc_q   <= 1'b0;
    end else begin
      // set wins over clear
      if (match_i && mode_i == MODE_TIMER) irq_q <= 1'b1;
      else if (irq_clr_i)                  irq_q <= 1'b0;
      if (wdog_hit) begin
        pulse_q <= LEN;
        osc_q   <= subclk_i;
      end else if (pulse_q != '0) begin
        pulse_q <= pulse_q - ONE;
      end
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = (pulse_q != '0);
  assign osc_on_o  = rst_req_o & osc_q;
endmodule

// File: rtl/dual_wdt.sv
module dual_wdt
  import dual_wdt_pkg::*;
#(
  parameter int unsigned CNT_W     = 7,
  parameter int unsigned CTL_W     = 8,
  parameter int unsigned EN_BIT    = 5,
  parameter int unsigned PULSE_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W:0]   cmp_wdata_i,
  input  logic             tick_i,
  input  logic             stop_i,
  input  logic             subclk_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W:0]   cmp_rd_o,
  output logic             irq_o,
  output logic             rst_req_o,
  output logic             osc_on_o
);
  wdt_mode_e        mode;
  logic [CNT_W-1:0] cmp;
  logic             clr;
  logic             match;

  dual_wdt_regs #(.CNT_W(CNT_W), .CTL_W(CTL_W), .EN_BIT(EN_BIT)) u_regs (
    .clk_i, .rst_ni, .ctl_we_i, .ctl_wdata_i, .cmp_we_i, .cmp_wdata_i,
    .mode_o(mode), .cmp_o(cmp), .clr_o(clr)
  );

  dual_wdt_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i, .stop_i, .clr_i(clr), .cmp_i(cmp),
    .cnt_o, .match_o(match)
  );

  dual_wdt_evt #(.PULSE_LEN(PULSE_LEN)) u_evt (
    .clk_i, .rst_ni, .match_i(match), .mode_i(mode), .subclk_i, .irq_clr_i,
    .irq_o, .rst_req_o, .osc_on_o
  );

  assign cmp_rd_o = {1'b0, cmp};
endmodule

// File: rtl/dual_wdt_chk.sv
module dual_wdt_chk #(
  parameter int unsigned CNT_W = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmp_we_i,
  input logic [CNT_W:0]   cmp_wdata_i,
  input logic             tick_i,
  input logic             stop_i,
  input logic             irq_clr_i,
  input logic [CNT_W-1:0] cnt_o,
  input logic [CNT_W:0]   cmp_rd_o,
  input logic             irq_o,
  input logic             rst_req_o,
  input logic             osc_on_o
);
  logic clr_w;
  assign clr_w = cmp_we_i & cmp_wdata_i[CNT_W];

  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !stop_i && !clr_w) |=>
      (cnt_o == CNT_W'($past(cnt_o) + 1'b1)) || (cnt_o == '0));

  a_r10_stop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !clr_w) |=> $stable(cnt_o));

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_w |=> (cnt_o == '0));

  a_r8_rd_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_rd_o[CNT_W] == 1'b0);

  a_r9_clear_no_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_w && tick_i) |=> !$rose(irq_o) && !$rose(rst_req_o));

  a_r7_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);

  a_r6_mode_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($rose(irq_o) && $rose(rst_req_o)));

  a_r11_osc_in_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_on_o |-> rst_req_o);
endmodule

bind dual_wdt dual_wdt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i, .rst_ni, .cmp_we_i, .cmp_wdata_i, .tick_i, .stop_i, .irq_clr_i,
  .cnt_o, .cmp_rd_o, .irq_o, .rst_req_o, .osc_on_o
);

// File: tb/dual_wdt_tb.sv
`timescale 1ns/1ps
module dual_wdt_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctl_we_i = 1'b0;
  logic [7:0] ctl_wdata_i = '0;
  logic       cmp_we_i = 1'b0;
  logic [7:0] cmp_wdata_i = '0;
  logic       tick_i = 1'b0, stop_i = 1'b0, subclk_i = 1'b0, irq_clr_i = 1'b0;
  logic [6:0] cnt_o;
  logic [7:0] cmp_rd_o;
  logic       irq_o, rst_req_o, osc_on_o;

  int n_chk = 0, n_fail = 0;

  // reference state
  logic       m_en;
  logic [6:0] m_cmp, m_cnt;
  logic       m_irq, m_osc;
  int         m_pulse;

  always #2 clk_i = ~clk_i;

  dual_wdt u_dut (
    .clk_i, .rst_ni, .ctl_we_i, .ctl_wdata_i, .cmp_we_i, .cmp_wdata_i,
    .tick_i, .stop_i, .subclk_i, .irq_clr_i,
    .cnt_o, .cmp_rd_o, .irq_o, .rst_req_o, .osc_on_o
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [31:0] a, e;
    a = {cnt_o, cmp_rd_o, irq_o, rst_req_o, osc_on_o};
    e = {m_cnt, 1'b0, m_cmp, m_irq, m_pulse != 0, (m_pulse != 0) && m_osc};
    check(tag, a, e, "cnt|cmp|irq|rst|osc");
  endtask

  function automatic logic model_match(logic adv);
    if (!adv) return 1'b0;
    if (m_cmp == 0) return m_cnt == 0;
    return 7'(m_cnt + 7'd1) == m_cmp;
  endfunction

  task automatic model_step();
    logic clr, adv, mt;
    clr = cmp_we_i & cmp_wdata_i[7];
    adv = tick_i & !stop_i & !clr;
    mt  = model_match(adv);
    if (mt && !m_en) m_irq = 1'b1;
    else if (irq_clr_i) m_irq = 1'b0;
    if (mt && m_en) begin m_pulse = 4; m_osc = subclk_i; end
    else if (m_pulse != 0) m_pulse--;
    if (clr || mt) m_cnt = '0;
    else if (adv) m_cnt = 7'(m_cnt + 7'd1);
    if (cmp_we_i) m_cmp = cmp_wdata_i[6:0];
    if (ctl_we_i) m_en = ctl_wdata_i[5];
  endtask

  // apply inputs for one edge, update model, compare, idle inputs
  task automatic step(string tag, logic tk, logic st = 0, logic cw = 0,
                      logic [7:0] cd = 0, logic kw = 0, logic [7:0] kd = 0,
                      logic ic = 0, logic sc = 0);
    tick_i = tk; stop_i = st; cmp_we_i = cw; cmp_wdata_i = cd;
    ctl_we_i = kw; ctl_wdata_i = kd; irq_clr_i = ic; subclk_i = sc;
    @(posedge clk_i); #1;
    model_step();
    check_all(tag);
    tick_i = 0; stop_i = 0; cmp_we_i = 0; ctl_we_i = 0; irq_clr_i = 0;
  endtask

  initial begin
    #(4ns * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_en = 0; m_cmp = 7'h7F; m_cnt = 0; m_irq = 0; m_osc = 0; m_pulse = 0;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    check_all("R1");
    check("R1", cmp_rd_o, 8'h7F, "reset limit");

    // R3 plain counting, R10 stop
    for (int i = 0; i < 5; i++) step("R3", 1);
    check("R3", cnt_o, 7'd5, "count after 5 ticks");
    for (int i = 0; i < 4; i++) step("R10", 1, 1);
    check("R10", cnt_o, 7'd5, "held in stop");
    step("R10", 1);
    check("R10", cnt_o, 7'd6, "resume after stop");

    // R8 write without clear keeps count, with clear zeroes it
    step("R8", 0, 0, 1, 8'h03);
    check("R8", cnt_o, 7'd6, "no clear when bit7=0");
    step("R8", 0, 0, 1, 8'h83);
    check("R8", cmp_rd_o, 8'h03, "bit7 not stored");
    check("R8", cnt_o, 7'd0, "clear");

    // R4/R7 timer mode, limit 3
    step("R4", 1); step("R4", 1);
    check("R7", irq_o, 1'b0, "no flag before limit");
    step("R4", 1);
    check("R7", irq_o, 1'b1, "flag on 3rd tick");
    check("R4", cnt_o, 7'd0, "restart after match");
    step("R7", 0);
    check("R7", irq_o, 1'b1, "flag sticky");
    step("R7", 0, 0, 0, 0, 0, 0, 1);
    check("R7", irq_o, 1'b0, "flag cleared");

    // R12 match with clear
    step("R12", 1); step("R12", 1);
    step("R12", 1, 0, 0, 0, 0, 0, 1);
    check("R12", irq_o, 1'b1, "set wins");
    step("R12", 0, 0, 0, 0, 0, 0, 1);

    // R9 tick with clearing write at would-be match
    step("R9", 1); step("R9", 1);
    step("R9", 1, 0, 1, 8'h83);
    check("R9", irq_o, 1'b0, "no match on clear");
    check("R9", cnt_o, 7'd0, "cleared");

    // R2 mode bit: other bits ignored
    step("R2", 0, 0, 0, 0, 1, 8'hDF);
    step("R2", 0, 0, 1, 8'h80);  // limit 0
    step("R5", 1);
    check("R2", irq_o, 1'b1, "timer mode kept when bit5=0");
    step("R2", 0, 0, 0, 0, 0, 0, 1);
    step("R2", 0, 0, 0, 0, 1, 8'h20);

    // R6/R11 watchdog pulse, limit 0 each tick
    step("R6", 1, 0, 0, 0, 0, 0, 0, 1);
    check("R11", osc_on_o, 1'b1, "osc request in sub clock");
    for (int i = 0; i < 3; i++) begin
      step("R6", 0);
      check("R6", rst_req_o, 1'b1, "pulse held");
    end
    step("R6", 0);
    check("R6", rst_req_o, 1'b0, "pulse ended after 4");
    check("R6", irq_o, 1'b0, "no flag in watchdog mode");
    step("R11", 1, 0, 0, 0, 0, 0, 0, 0);
    check("R11", osc_on_o, 1'b0, "no osc request in main clock");
    step("R6", 0); step("R6", 1);
    check("R6", rst_req_o, 1'b1, "retrigger");
    for (int i = 0; i < 6; i++) step("R6", 0);

    // R4 full limit 127
    step("R4", 0, 0, 1, 8'hFF);
    for (int i = 0; i < 126; i++) step("R4", 1);
    check("R4", rst_req_o, 1'b0, "no event before 127");
    step("R4", 1);
    check("R4", rst_req_o, 1'b1, "event on 127th tick");
    for (int i = 0; i < 5; i++) step("R4", 0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic cw, kw;
      logic [7:0] cd;
      cw = ($urandom % 20) == 0;
      kw = ($urandom % 40) == 0;
      cd = {($urandom % 3) == 0, 4'd0, 3'($urandom)};
      step("R4", ($urandom % 2) == 1, ($urandom % 10) == 0, cw, cd,
           kw, 8'($urandom), ($urandom % 8) == 0, ($urandom % 2) == 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule